// File: doc/BRIEF.md
# Validation Pulse and Event Tag Sequencer

This block runs once for every fast trigger. After the fast trigger ends it watches a set of ready-made validation request bits, masked by the request pattern that was latched with the trigger. If a request shows up in time, it drives a single validation pulse at a programmed point in the event. If no request shows up, it lets the event lapse and frees the trigger system at once.

The validation line carries one of two timings, and software picks which one. An early (coding) validation must sit between a minimum gap after the trigger and the end of the shaping gate. A late (readout) validation must sit between the end of the shaping gate and the end of conversion. Each validation carries the low four bits of a running validation count on a separate bus.

In the common-deadtime mode, the block holds the trigger system dead after a validation. It waits until the readout-busy line chosen by software drops, or until a programmable wait limit expires. When the limit expires it raises an error strobe. In the free-running mode it releases as soon as the pulse ends. All times are counted in clock ticks. Tick 0 is the first cycle after the clock edge that samples the trigger-end strobe.

Top module: `valseq`

## Requirements
- R1: While reset is held, and after it is released, the validation pulse, event tag, validation count, release, lapse and wait-error outputs are all 0.
- R2: Early timing (val_kind=0): the effective start S is the larger of cfg_start and the MIN_GAP parameter. The pulse rises at tick S+1.
- R3: Early timing: the pulse lasts min(cfg_width, cfg_gate−S) cycles. If cfg_gate ≤ S or cfg_width is 0, no pulse is driven and the event lapses at tick S.
- R4: Late timing (val_kind=1): S is the larger of cfg_start and cfg_gate+1. The pulse rises at tick S+1 and lasts min(cfg_width, cfg_conv−S) cycles. If cfg_conv ≤ S or cfg_width is 0, the event lapses at tick S.
- R5: A request counts only if its val_req bit is high while the same bit of the pattern latched with the trigger end is also set.
  - If cfg_timeout < S and no request has counted by tick cfg_timeout, the event lapses at that tick.
  - Otherwise, a request must have counted by tick S, or the event lapses at tick S.
  - A lapse gives a one-cycle ev_failed together with ft_release in the following cycle, and no pulse.
- R6: evt_num always equals the low 4 bits of val_count, so it wraps from 15 to 0. During a pulse it shows the value from before that validation. val_count rises by exactly 1 in the cycle after each pulse ends.
- R7: With mode_common=0, ft_release pulses for one cycle in the first cycle after the pulse ends. The readout-busy lines have no effect in this mode.
- R8: With mode_common=1, the block watches one readout-busy line after the pulse: ro_busy_a when ro_src_sel=0, ro_busy_b when ro_src_sel=1. ft_release pulses in the cycle after the first cycle in which the selected line is low. The other line is ignored.
- R9: With mode_common=1, if the selected line stays high for cfg_ro_timeout+1 cycles after the pulse, ft_release and ro_timeout_err pulse together for one cycle.
- R10: An ft_start while an event is in progress has no effect. An ft_end or val_req with no preceding ft_start has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ft_start | input | 1 | Fast-trigger start strobe |
| ft_end | input | 1 | Fast-trigger end strobe; opens tick counting |
| req_pattern | input | NREQ | Request mask, latched at trigger end |
| val_req | input | NREQ | Validation request bits |
| ro_busy_a | input | 1 | Readout-busy line, first source (high = busy) |
| ro_busy_b | input | 1 | Readout-busy line, second source |
| ro_src_sel | input | 1 | 0 selects ro_busy_a, 1 selects ro_busy_b |
| mode_common | input | 1 | 1 = wait for readout before release |
| val_kind | input | 1 | 0 = early timing, 1 = late timing |
| cfg_start | input | TW | Requested pulse start tick |
| cfg_width | input | TW | Requested pulse width in ticks |
| cfg_gate | input | TW | Shaping-gate end tick |
| cfg_conv | input | TW | Conversion end tick |
| cfg_timeout | input | TW | Request decision limit tick |
| cfg_ro_timeout | input | TW | Readout wait limit |
| val_pulse | output | 1 | Validation pulse |
| evt_num | output | 4 | Event tag |
| val_count | output | CW | Validation count |
| ft_release | output | 1 | One-cycle strobe: next fast trigger allowed |
| ev_failed | output | 1 | One-cycle strobe: event lapsed |
| ro_timeout_err | output | 1 | One-cycle strobe: readout wait limit hit |

## Verification
The bench places requests exactly on the decision tick, one tick past the decision limit, and behind a cleared mask bit. A design that is off by one on the deadline or skips the mask would validate events that should lapse. It uses start values below the minimum gap and before the gate end, plus widths that overrun the gate or the conversion end. A design with the wrong clamping or clipping shows a shifted rise cycle or a wrong pulse length. In common-deadtime runs the unselected busy line is held high, and separate runs cover a readout that never finishes and one that is already done. A wrong source select would then hang until the wait limit, and a wrong limit count would release one cycle early or late. More than sixteen validations in a row check the tag wrap. A stray trigger-start during an event also gets a run: a design that restarted on it would move the pulse.

// File: rtl/valseq_pkg.sv
package valseq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_TRIG  = 3'd1,
    ST_WAIT  = 3'd2,
    ST_PULSE = 3'd3,
    ST_DRAIN = 3'd4
  } vs_state_e;
  localparam int TAG_W = 4;
endpackage

// File: rtl/valseq_window.sv
module valseq_window #(
  parameter int TW      = 16,
  parameter int MIN_GAP = 125
) (
  input  logic          kind,
  input  logic [TW-1:0] cfg_start,
  input  logic [TW-1:0] cfg_width,
  input  logic [TW-1:0] cfg_gate,
  input  logic [TW-1:0] cfg_conv,
  output logic [TW-1:0] eff_start,
  output logic [TW-1:0] eff_width,
  output logic          fits
);
  localparam int XW = TW + 1;
  localparam logic [XW-1:0] GAP = XW'(MIN_GAP);
  localparam logic [XW-1:0] ONE = XW'(1);

  logic [XW-1:0] start_x, gate_x, conv_x, width_x;
  logic [XW-1:0] s_early, s_late, s_sel, lim, room;

  always_comb begin
    start_x   = {1'b0, cfg_start};
    gate_x    = {1'b0, cfg_gate};
    conv_x    = {1'b0, cfg_conv};
    width_x   = {1'b0, cfg_width};
    s_early   = (start_x < GAP) ? GAP : start_x;
    s_late    = (start_x > gate_x) ? start_x : (gate_x + ONE);
    s_sel     = kind ? s_late : s_early;
    lim       = kind ? conv_x : gate_x;
    fits      = (lim > s_sel) && (cfg_width != '0);
    room      = lim - s_sel;
    eff_start = s_sel[TW-1:0];
    eff_width = (width_x < room) ? cfg_width : room[TW-1:0];
  end
endmodule

// File: rtl/valseq_evtcnt.sv
module valseq_evtcnt #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  output logic [CW-1:0] count
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = inc;
    cnt_d  = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  assert_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(inc) |-> (cnt_q == $past(cnt_q) + CW'(1)));
  assert_count_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(inc) |-> $stable(cnt_q));
endmodule

// File: rtl/valseq_ctrl.sv
module valseq_ctrl
  import valseq_pkg::*;
#(
  parameter int TW      = 16,
  parameter int NREQ    = 8,
  parameter int MIN_GAP = 125
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ft_start,
  input  logic            ft_end,
  input  logic [NREQ-1:0] req_pattern,
  input  logic [NREQ-1:0] val_req,
  input  logic            ro_line,
  input  logic            mode_common,
  input  logic            kind,
  input  logic [TW-1:0]   eff_start,
  input  logic [TW-1:0]   eff_width,
  input  logic            fits,
  input  logic [TW-1:0]   cfg_timeout,
  input  logic [TW-1:0]   cfg_ro_timeout,
  input  logic [TW-1:0]   cfg_gate,
  input  logic [TW-1:0]   cfg_conv,
  output logic            val_pulse,
  output logic            inc,
  output logic            release_o,
  output logic            failed_o,
  output logic            ro_err_o
);
  localparam int XW = TW + 1;

  vs_state_e       state_q, state_d;
  logic [TW-1:0]   tick_q, tick_d;
  logic [TW-1:0]   wcnt_q, wcnt_d;
  logic [TW-1:0]   wlen_q, wlen_d;
  logic [TW-1:0]   rcnt_q, rcnt_d;
  logic [NREQ-1:0] pat_q, pat_d;
  logic            hit_q, hit_d;
  logic            rel_q, rel_d, fail_q, fail_d, err_q, err_d;
  logic            req_now, hit_now;

  always_comb begin
    state_d = state_q;
    tick_d  = tick_q;
    wcnt_d  = wcnt_q;
    wlen_d  = wlen_q;
    rcnt_d  = rcnt_q;
    pat_d   = pat_q;
    hit_d   = hit_q;
    rel_d   = 1'b0;
    fail_d  = 1'b0;
    err_d   = 1'b0;
    inc     = 1'b0;
    req_now = |(val_req & pat_q);
    hit_now = hit_q | req_now;
    unique case (state_q)
      ST_IDLE: begin
        if (ft_start) state_d = ST_TRIG;
      end
      ST_TRIG: begin
        if (ft_end) begin
          state_d = ST_WAIT;
          tick_d  = '0;
          hit_d   = 1'b0;
          pat_d   = req_pattern;
        end
      end
      ST_WAIT: begin
        hit_d = hit_now;
        if (tick_q == eff_start) begin
          if (hit_now && fits) begin
            state_d = ST_PULSE;
            wlen_d  = eff_width;
            wcnt_d  = '0;
            tick_d  = tick_q + TW'(1);
          end else begin
            state_d = ST_IDLE;
            fail_d  = 1'b1;
            rel_d   = 1'b1;
          end
        end else if ((tick_q == cfg_timeout) && !hit_now) begin
          state_d = ST_IDLE;
          fail_d  = 1'b1;
          rel_d   = 1'b1;
        end else begin
          tick_d = tick_q + TW'(1);
        end
      end
      ST_PULSE: begin
        tick_d = tick_q + TW'(1);
        if (wcnt_q == wlen_q - TW'(1)) begin
          inc = 1'b1;
          if (mode_common) begin
            state_d = ST_DRAIN;
            rcnt_d  = '0;
          end else begin
            state_d = ST_IDLE;
            rel_d   = 1'b1;
          end
        end else begin
          wcnt_d = wcnt_q + TW'(1);
        end
      end
      ST_DRAIN: begin
        if (!ro_line) begin
          state_d = ST_IDLE;
          rel_d   = 1'b1;
        end else if (rcnt_q == cfg_ro_timeout) begin
          state_d = ST_IDLE;
          rel_d   = 1'b1;
          err_d   = 1'b1;
        end else begin
          rcnt_d = rcnt_q + TW'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tick_q  <= '0;
      wcnt_q  <= '0;
      wlen_q  <= '0;
      rcnt_q  <= '0;
      pat_q   <= '0;
      hit_q   <= 1'b0;
      rel_q   <= 1'b0;
      fail_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      tick_q  <= tick_d;
      wcnt_q  <= wcnt_d;
      wlen_q  <= wlen_d;
      rcnt_q  <= rcnt_d;
      pat_q   <= pat_d;
      hit_q   <= hit_d;
      rel_q   <= rel_d;
      fail_q  <= fail_d;
      err_q   <= err_d;
    end
  end

  assign val_pulse = (state_q == ST_PULSE);
  assign release_o = rel_q;
  assign failed_o  = fail_q;
  assign ro_err_o  = err_q;

  assert_early_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(val_pulse) && !kind) |-> (XW'(tick_q) > XW'(MIN_GAP)));
  assert_early_in_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (val_pulse && !kind) |-> (tick_q <= cfg_gate));
  assert_late_after_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (val_pulse && kind) |-> ((XW'(tick_q) > XW'(cfg_gate) + XW'(1)) && (tick_q <= cfg_conv)));
  assert_lapse_releases_R5: assert property (@(posedge clk) disable iff (!rst_n)
    failed_o |-> (release_o && !val_pulse));
  assert_free_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(val_pulse) && !mode_common) |-> release_o);
  assert_drain_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DRAIN) |-> (rcnt_q <= cfg_ro_timeout));
  assert_err_releases_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ro_err_o |-> release_o);
  assert_stray_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_WAIT) && ft_start) |=> (state_q != ST_TRIG));
endmodule

// File: rtl/valseq.sv
module valseq
  import valseq_pkg::*;
#(
  parameter int TW          = 16,
  parameter int NREQ        = 8,
  parameter int CW          = 16,
  parameter int MIN_GAP     = 125,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ft_start,
  input  logic            ft_end,
  input  logic [NREQ-1:0] req_pattern,
  input  logic [NREQ-1:0] val_req,
  input  logic            ro_busy_a,
  input  logic            ro_busy_b,
  input  logic            ro_src_sel,
  input  logic            mode_common,
  input  logic            val_kind,
  input  logic [TW-1:0]   cfg_start,
  input  logic [TW-1:0]   cfg_width,
  input  logic [TW-1:0]   cfg_gate,
  input  logic [TW-1:0]   cfg_conv,
  input  logic [TW-1:0]   cfg_timeout,
  input  logic [TW-1:0]   cfg_ro_timeout,
  output logic            val_pulse,
  output logic [3:0]      evt_num,
  output logic [CW-1:0]   val_count,
  output logic            ft_release,
  output logic            ev_failed,
  output logic            ro_timeout_err
);
  logic [SYNC_STAGES-1:0] rs_q;
  logic                   rst_int_n;
  logic [TW-1:0]          eff_start, eff_width;
  logic                   fits, inc, ro_line;

  generate
    if (SYNC_STAGES > 1) begin : g_sync_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rs_q <= '0;
        else        rs_q <= {rs_q[SYNC_STAGES-2:0], 1'b1};
      end
    end else begin : g_sync_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rs_q <= '0;
        else        rs_q <= 1'b1;
      end
    end
  endgenerate
  assign rst_int_n = rs_q[SYNC_STAGES-1];

  assign ro_line = ro_src_sel ? ro_busy_b : ro_busy_a;

  valseq_window #(.TW(TW), .MIN_GAP(MIN_GAP)) u_window (
    .kind      (val_kind),
    .cfg_start (cfg_start),
    .cfg_width (cfg_width),
    .cfg_gate  (cfg_gate),
    .cfg_conv  (cfg_conv),
    .eff_start (eff_start),
    .eff_width (eff_width),
    .fits      (fits)
  );

  valseq_ctrl #(.TW(TW), .NREQ(NREQ), .MIN_GAP(MIN_GAP)) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_int_n),
    .ft_start       (ft_start),
    .ft_end         (ft_end),
    .req_pattern    (req_pattern),
    .val_req        (val_req),
    .ro_line        (ro_line),
    .mode_common    (mode_common),
    .kind           (val_kind),
    .eff_start      (eff_start),
    .eff_width      (eff_width),
    .fits           (fits),
    .cfg_timeout    (cfg_timeout),
    .cfg_ro_timeout (cfg_ro_timeout),
    .cfg_gate       (cfg_gate),
    .cfg_conv       (cfg_conv),
    .val_pulse      (val_pulse),
    .inc            (inc),
    .release_o      (ft_release),
    .failed_o       (ev_failed),
    .ro_err_o       (ro_timeout_err)
  );

  valseq_evtcnt #(.CW(CW)) u_cnt (
    .clk   (clk),
    .rst_n (rst_int_n),
    .inc   (inc),
    .count (val_count)
  );

  assign evt_num = val_count[TAG_W-1:0];
endmodule

// File: tb/valseq_test.sv
module valseq_test;
  localparam int TW = 12, NREQ = 8, CW = 16, GAP = 10, NONE = 4095;

  logic clk = 1'b0;
  logic rst_n;
  logic ft_start, ft_end, ro_busy_a, ro_busy_b, ro_src_sel, mode_common, val_kind;
  logic [NREQ-1:0] req_pattern, val_req;
  logic [TW-1:0] cfg_start, cfg_width, cfg_gate, cfg_conv, cfg_timeout, cfg_ro_timeout;
  logic val_pulse, ft_release, ev_failed, ro_timeout_err;
  logic [3:0] evt_num;
  logic [CW-1:0] val_count;

  int total = 0, bad = 0, exp_cnt = 0;

  always #2 clk = ~clk;

  valseq #(.TW(TW), .NREQ(NREQ), .CW(CW), .MIN_GAP(GAP)) uut (.*);

  typedef struct packed {
    logic kind; logic common; logic sel;
    logic [11:0] start; logic [11:0] width; logic [11:0] gate; logic [11:0] conv;
    logic [11:0] tmo; logic [11:0] req; logic mask; logic [11:0] hold; logic [11:0] rtmo;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t TAB [NV] = '{
    '{1'b0,1'b0,1'b0,12'd20,12'd8, 12'd100,12'd200,12'd50,12'd5, 1'b1,12'd0,  12'd0 }, // R2 base
    '{1'b0,1'b0,1'b0,12'd3, 12'd8, 12'd100,12'd200,12'd50,12'd0, 1'b1,12'd0,  12'd0 }, // R2 clamp to gap
    '{1'b0,1'b0,1'b0,12'd20,12'd50,12'd40, 12'd200,12'd50,12'd2, 1'b1,12'd0,  12'd0 }, // R3 clip at gate
    '{1'b0,1'b0,1'b0,12'd20,12'd8, 12'd15, 12'd200,12'd50,12'd2, 1'b1,12'd0,  12'd0 }, // R3 no room
    '{1'b1,1'b0,1'b0,12'd5, 12'd10,12'd30, 12'd60, 12'd50,12'd3, 1'b1,12'd0,  12'd0 }, // R4 after gate
    '{1'b1,1'b0,1'b0,12'd50,12'd40,12'd30, 12'd70, 12'd60,12'd3, 1'b1,12'd0,  12'd0 }, // R4 clip at conv
    '{1'b0,1'b0,1'b0,12'd20,12'd8, 12'd100,12'd200,12'd8, 12'd4095,1'b1,12'd0,12'd0 }, // R5 no request
    '{1'b0,1'b0,1'b0,12'd20,12'd8, 12'd100,12'd200,12'd50,12'd2, 1'b0,12'd0,  12'd0 }, // R5 masked
    '{1'b0,1'b0,1'b0,12'd20,12'd8, 12'd100,12'd200,12'd8, 12'd9, 1'b1,12'd0,  12'd0 }, // R5 late by one
    '{1'b0,1'b0,1'b0,12'd20,12'd8, 12'd100,12'd200,12'd8, 12'd8, 1'b1,12'd0,  12'd0 }, // R5 on limit
    '{1'b0,1'b1,1'b0,12'd20,12'd8, 12'd100,12'd200,12'd50,12'd5, 1'b1,12'd5,  12'd50}, // R8 line a
    '{1'b0,1'b1,1'b1,12'd20,12'd8, 12'd100,12'd200,12'd50,12'd5, 1'b1,12'd3,  12'd50}, // R8 line b
    '{1'b0,1'b1,1'b0,12'd20,12'd8, 12'd100,12'd200,12'd50,12'd5, 1'b1,12'd100,12'd6 }, // R9 wait limit
    '{1'b0,1'b1,1'b1,12'd20,12'd8, 12'd100,12'd200,12'd50,12'd5, 1'b1,12'd0,  12'd50}  // R8 already done
  };

  task automatic check(input bit ok, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v, input bit poke);
    int s, lim, w, x, r, d, lwhen, e_rel;
    bit fit, ok, e_err;
    int rise, pw, rel, ev;
    bit f, e;
    s   = v.kind ? ((v.start > v.gate) ? int'(v.start) : int'(v.gate) + 1)
                 : ((v.start < GAP) ? GAP : int'(v.start));
    lim = v.kind ? int'(v.conv) : int'(v.gate);
    fit = (lim > s) && (v.width != 0);
    w   = fit ? ((int'(v.width) < lim - s) ? int'(v.width) : lim - s) : 0;
    if (int'(v.tmo) < s) begin
      if (v.mask && int'(v.req) <= int'(v.tmo)) begin ok = fit; x = s; end
      else begin ok = 1'b0; x = int'(v.tmo); end
    end else begin
      ok = v.mask && (int'(v.req) <= s) && fit; x = s;
    end
    r = s + 1; d = r + w; lwhen = 100000; e_err = 1'b0;
    if (!ok) e_rel = x + 1;
    else if (!v.common) e_rel = d;
    else begin
      lwhen = d + int'(v.hold);
      if (d + int'(v.rtmo) < lwhen) begin e_rel = d + int'(v.rtmo) + 1; e_err = 1'b1; end
      else e_rel = lwhen + 1;
    end

    val_kind = v.kind; mode_common = v.common; ro_src_sel = v.sel;
    cfg_start = v.start; cfg_width = v.width; cfg_gate = v.gate; cfg_conv = v.conv;
    cfg_timeout = v.tmo; cfg_ro_timeout = v.rtmo;
    req_pattern = v.mask ? 8'h08 : 8'hF7;
    val_req = '0; ro_busy_a = 1'b1; ro_busy_b = 1'b1;

    @(negedge clk) ft_start = 1'b1;
    @(negedge clk) ft_start = 1'b0;
    @(negedge clk);
    ft_end = 1'b1;
    @(negedge clk) ft_end = 1'b0;
    rise = -1; pw = 0; rel = -1; ev = -1; f = 1'b0; e = 1'b0;
    for (int m = 0; m < 1000; m++) begin
      if (val_pulse) begin
        if (rise < 0) begin rise = m; ev = int'(evt_num); end
        pw++;
      end
      if (ft_release) begin rel = m; f = ev_failed; e = ro_timeout_err; break; end
      if (m == int'(v.req)) val_req[3] = 1'b1;
      if (v.common && m == lwhen) begin
        if (v.sel) ro_busy_b = 1'b0; else ro_busy_a = 1'b0;
      end
      ft_start = (poke && m == 2);
      @(negedge clk);
    end
    ft_start = 1'b0; val_req = '0; ro_busy_a = 1'b0; ro_busy_b = 1'b0;

    check(f == !ok, "lapse flag (R3 R4 R5)", int'(f), int'(!ok));
    check(rel == e_rel, "release cycle (R5 R7 R8 R9)", rel, e_rel);
    check(e == e_err, "wait error strobe (R9)", int'(e), int'(e_err));
    if (ok) begin
      check(rise == r, "pulse start (R2 R4 R10)", rise, r);
      check(pw == w, "pulse length (R3 R4)", pw, w);
      check(ev == (exp_cnt % 16), "tag during pulse (R6)", ev, exp_cnt % 16);
      exp_cnt++;
    end else begin
      check(pw == 0, "no pulse on lapse (R5)", pw, 0);
    end
    check(int'(val_count) == exp_cnt, "count after event (R6)", int'(val_count), exp_cnt);
    check(int'(evt_num) == exp_cnt % 16, "tag follows count (R6)", int'(evt_num), exp_cnt % 16);
    @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit seen;
    rst_n = 1'b0; ft_start = 1'b0; ft_end = 1'b0; val_req = '0; req_pattern = '0;
    ro_busy_a = 1'b0; ro_busy_b = 1'b0; ro_src_sel = 1'b0; mode_common = 1'b0; val_kind = 1'b0;
    cfg_start = '0; cfg_width = '0; cfg_gate = '0; cfg_conv = '0; cfg_timeout = '0; cfg_ro_timeout = '0;
    repeat (3) @(negedge clk);
    // R1: state held in reset
    check(!val_pulse && !ft_release && !ev_failed && !ro_timeout_err, "outputs in reset (R1)",
          int'({val_pulse, ft_release, ev_failed, ro_timeout_err}), 0);
    check(val_count == '0 && evt_num == '0, "count in reset (R1)", int'(val_count), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(val_count == '0 && !val_pulse && !ft_release, "after reset (R1)", int'(val_count), 0);

    // table walk
    for (int i = 0; i < NV; i++) run_vec(TAB[i], 1'b0);

    // R10: stray start during an event
    run_vec(TAB[0], 1'b1);

    // R10: end strobe and requests with no trigger start
    req_pattern = 8'hFF; val_req = 8'hFF; mode_common = 1'b0;
    @(negedge clk) ft_end = 1'b1;
    @(negedge clk) ft_end = 1'b0;
    seen = 1'b0;
    for (int k = 0; k < 40; k++) begin
      if (val_pulse || ft_release) seen = 1'b1;
      @(negedge clk);
    end
    val_req = '0;
    check(!seen, "stray end strobe ignored (R10)", int'(seen), 0);
    check(int'(val_count) == exp_cnt, "count unchanged by stray strobe (R10)", int'(val_count), exp_cnt);

    // R6: run through tag wrap
    for (int j = 0; j < 18; j++) run_vec(TAB[1], 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule